// File: doc/BRIEF.md
# Local Second Marker with Phase Timestamp Readout

The block divides a 10 MHz reference clock down to one pulse per second and records where a second, external one-pulse-per-second signal falls within that local second. A free-running counter runs from zero up to the last count of the second and then wraps. Its top bit is the local seconds output, so the pulse is high only for the upper part of the count range and its width is fixed but not half the period. Each rising edge of the external reference latches the counter into a capture register. A host then reads that value serially and gets the phase offset, in reference clocks, between the local second and the reference.

All three external inputs are asynchronous: the reference pulse, the host shift strobe and the host load strobe. Each one passes through a two-flop synchroniser followed by a rising-edge detector. Every register runs on the single reference clock, and the strobes act only as clock enables. A small readout state machine tracks whether a capture is waiting to be read. It has three states: `RD_EMPTY` (no capture since reset), `RD_HELD` (a capture is waiting) and `RD_SHIFT` (the host has begun shifting). Its transitions are:
- capture: `RD_EMPTY`→`RD_HELD` and `RD_SHIFT`→`RD_HELD`
- recapture: `RD_HELD`→`RD_HELD`, which raises the overrun flag
- start-read: `RD_HELD`→`RD_SHIFT`, on the first shift edge

A capture takes priority over a shift edge in the same cycle.

Top module: `pps_capture`

## Requirements
- R1: The counter steps by one on every clock from 0 up to MOD-1, then returns to 0. Rising edges of `pps_o` are therefore exactly MOD clocks apart.
- R2: `pps_o` is high exactly while the counter is in the range 2^(CNT_W-1) to MOD-1, and low otherwise. With CNT_W=10 and MOD=1000 it is high for 488 clocks per period.
- R3: When `ref_pps_i` rises, the capture register takes the value the counter held just before the third clock edge that samples the input high. If the input is first seen high after the edge that left the counter at c, the captured value is (c+2) mod MOD.
- R4: One rising edge of `ref_pps_i` causes exactly one capture. Holding the input high causes no further capture.
- R5: A rising edge of `load_stb_i` copies the capture register into the shift register, and `ser_o` then presents the capture's most significant bit.
- R6: Each rising edge of `shift_stb_i` shifts the register left by one place. The CNT_W bits therefore appear on `ser_o` most significant first, bit CNT_W-1-i after i shift edges. A load edge in the same cycle wins over a shift edge.
- R7: `cap_valid_o` rises after every capture and falls on the first shift edge that follows it. A capture during shifting raises it again.
- R8: `overrun_o` is set when a capture arrives while `cap_valid_o` is high, and it is cleared by a load edge. The capture register then holds the newest value.
- R9: Synchronous reset clears the counter, the capture and shift registers and both flags, leaving `pps_o`, `ser_o`, `cap_valid_o` and `overrun_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pps_i | input | 1 | External reference seconds pulse, asynchronous |
| shift_stb_i | input | 1 | Host shift strobe, asynchronous; each rising edge shifts one bit |
| load_stb_i | input | 1 | Host load strobe, asynchronous; rising edge reloads the shift register |
| pps_o | output | 1 | Local seconds pulse (counter top bit) |
| ser_o | output | 1 | Serial timestamp data, most significant bit first |
| cap_valid_o | output | 1 | A capture is waiting to be read |
| overrun_o | output | 1 | A capture was overwritten before being read |

## Verification
The bench watches the local pulse over two full periods. This separates an off-by-one wrap point, which shows up as a period error, from a wrong threshold for the top bit, which shows up as a width error. Captures are placed at fixed phases, including just before the wrap, so that a wrong synchroniser depth or a missed modulo becomes visible in the read-back value. Further captures are placed at random phases. Back-to-back captures with no read in between check the overrun flag and that the newest value is kept. A reference pulse held high for many cycles must produce no second capture. A capture during a read must raise the valid flag again.

// File: rtl/pps_cap_pkg.sv
package pps_cap_pkg;

    typedef enum logic [1:0] {
        RD_EMPTY = 2'd0,
        RD_HELD  = 2'd1,
        RD_SHIFT = 2'd2
    } rd_state_t;

    localparam int STROBES   = 3;
    localparam int IDX_REF   = 0;
    localparam int IDX_SHIFT = 1;
    localparam int IDX_LOAD  = 2;

endpackage

// File: rtl/pps_sync_rise.sv
module pps_sync_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pps_divider.sv
module pps_divider #(
    parameter int CNT_W = 24,
    parameter int MOD   = 10_000_000
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pps_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MOD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
    assign pps_o = cnt_q[CNT_W-1];

endmodule

// File: rtl/pps_capture.sv
module pps_capture
    import pps_cap_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int MOD       = 10_000_000,
    parameter int SYNC_STGS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pps_i,
    input  logic shift_stb_i,
    input  logic load_stb_i,
    output logic pps_o,
    output logic ser_o,
    output logic cap_valid_o,
    output logic overrun_o
);

    logic [STROBES-1:0] raw_in;
    logic [STROBES-1:0] rise;
    logic               cap_pulse;
    logic               shift_pulse;
    logic               load_pulse;
    logic [CNT_W-1:0]   cnt_w;
    logic [CNT_W-1:0]   cap_q;
    logic [CNT_W-1:0]   shreg_q;
    logic               ovr_q;
    rd_state_t          state_q;
    rd_state_t          state_d;

    assign raw_in = {load_stb_i, shift_stb_i, ref_pps_i};

    for (genvar g = 0; g < STROBES; g++) begin : g_sync
        pps_sync_rise #(.STAGES(SYNC_STGS)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .async_i(raw_in[g]),
            .rise_o (rise[g])
        );
    end

    assign cap_pulse   = rise[IDX_REF];
    assign shift_pulse = rise[IDX_SHIFT];
    assign load_pulse  = rise[IDX_LOAD];

    pps_divider #(.CNT_W(CNT_W), .MOD(MOD)) u_div (
        .clk  (clk),
        .rst  (rst),
        .cnt_o(cnt_w),
        .pps_o(pps_o)
    );

    // capture and serial data path
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= '0;
            shreg_q <= '0;
        end else begin
            if (cap_pulse)
                cap_q <= cnt_w;
            if (load_pulse)
                shreg_q <= cap_q;
            else if (shift_pulse)
                shreg_q <= {shreg_q[CNT_W-2:0], 1'b0};
        end
    end

    // readout state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= RD_EMPTY;
        else
            state_q <= state_d;
    end

    // readout next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_EMPTY: if (cap_pulse)        state_d = RD_HELD;
            RD_HELD:  if (cap_pulse)        state_d = RD_HELD;
                      else if (shift_pulse) state_d = RD_SHIFT;
            RD_SHIFT: if (cap_pulse)        state_d = RD_HELD;
            default:                        state_d = RD_EMPTY;
        endcase
    end

    // overrun flag
    always_ff @(posedge clk) begin
        if (rst)
            ovr_q <= 1'b0;
        else if (cap_pulse && state_q == RD_HELD)
            ovr_q <= 1'b1;
        else if (load_pulse)
            ovr_q <= 1'b0;
    end

    // outputs
    always_comb begin
        cap_valid_o = (state_q == RD_HELD);
        overrun_o   = ovr_q;
        ser_o       = shreg_q[CNT_W-1];
    end

endmodule

// File: rtl/pps_capture_chk.sv
module pps_capture_chk #(
    parameter int CNT_W = 24,
    parameter int MOD   = 10_000_000
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cap_q,
    input logic [CNT_W-1:0] shreg_q,
    input logic             cap_pulse,
    input logic             shift_pulse,
    input logic             load_pulse,
    input logic             pps_o,
    input logic             ser_o,
    input logic             cap_valid_o,
    input logic             overrun_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MOD - 1);
    localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt == LAST |=> cnt == '0);

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        cnt != LAST |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R2
    pps_level_chk: assert property (@(posedge clk) disable iff (rst)
        pps_o == (cnt >= HALF && cnt <= LAST));

    // R3
    cap_take_chk: assert property (@(posedge clk) disable iff (rst)
        cap_pulse |=> cap_q == $past(cnt));

    // R5
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> shreg_q == $past(cap_q));

    // R6
    shift_bit_chk: assert property (@(posedge clk) disable iff (rst)
        shift_pulse && !load_pulse |=> ser_o == $past(shreg_q[CNT_W-2]));

    // R7
    valid_set_chk: assert property (@(posedge clk) disable iff (rst)
        cap_pulse |=> cap_valid_o);

    // R7
    valid_clr_chk: assert property (@(posedge clk) disable iff (rst)
        cap_valid_o && shift_pulse && !cap_pulse |=> !cap_valid_o);

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        cap_pulse && cap_valid_o |=> overrun_o);

    // R8
    overrun_clr_chk: assert property (@(posedge clk) disable iff (rst)
        load_pulse && !(cap_pulse && cap_valid_o) |=> !overrun_o);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cnt == '0 && !pps_o && !ser_o && !cap_valid_o && !overrun_o));

endmodule

bind pps_capture pps_capture_chk #(.CNT_W(CNT_W), .MOD(MOD)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt        (cnt_w),
    .cap_q      (cap_q),
    .shreg_q    (shreg_q),
    .cap_pulse  (cap_pulse),
    .shift_pulse(shift_pulse),
    .load_pulse (load_pulse),
    .pps_o      (pps_o),
    .ser_o      (ser_o),
    .cap_valid_o(cap_valid_o),
    .overrun_o  (overrun_o)
);

// File: tb/pps_capture_bench.sv
module pps_capture_bench;

    localparam int W    = 10;
    localparam int MOD  = 1000;
    localparam int HALF = 1 << (W - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_pps = 1'b0;
    logic shift_stb = 1'b0;
    logic load_stb = 1'b0;
    logic pps_o, ser_o, cap_valid_o, overrun_o;

    int vectors = 0;
    int errors  = 0;
    int mcnt    = 0;

    always #2.5 clk = ~clk;

    pps_capture #(.CNT_W(W), .MOD(MOD)) u_pps_capture (
        .clk        (clk),
        .rst        (rst),
        .ref_pps_i  (ref_pps),
        .shift_stb_i(shift_stb),
        .load_stb_i (load_stb),
        .pps_o      (pps_o),
        .ser_o      (ser_o),
        .cap_valid_o(cap_valid_o),
        .overrun_o  (overrun_o)
    );

    // specification model of the counter
    always @(posedge clk) begin
        if (rst) mcnt <= 0;
        else     mcnt <= (mcnt == MOD - 1) ? 0 : mcnt + 1;
    end

    function automatic int exp_capture(input int seen);
        return (seen + 2) % MOD;
    endfunction

    function automatic bit exp_pps(input int c);
        return (c >= HALF) && (c <= MOD - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_ref(output int expv, input int hold);
        @(negedge clk);
        expv = exp_capture(mcnt);
        ref_pps = 1'b1;
        repeat (hold) @(negedge clk);
        ref_pps = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic strobe(input bit is_load);
        @(negedge clk);
        if (is_load) load_stb = 1'b1; else shift_stb = 1'b1;
        repeat (4) @(negedge clk);
        if (is_load) load_stb = 1'b0; else shift_stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_word(output int v);
        logic [W-1:0] bits;
        strobe(1'b1);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            bits[W-1-i] = ser_o;
            strobe(1'b0);
        end
        v = int'(bits);
    endtask

    initial begin
        int e1, e2, got, hi_run, rise_at, period;
        void'($urandom(32'h5EC0_0D01));

        // R9: reset state
        repeat (5) @(negedge clk);
        chk(!pps_o && !ser_o && !cap_valid_o && !overrun_o, "R9", {pps_o, ser_o, cap_valid_o, overrun_o}, 0);
        rst = 1'b0;

        // R1/R2: period and width of the local pulse
        hi_run = 0; rise_at = -1; period = 0;
        for (int t = 0; t < 2 * MOD + 10; t++) begin
            @(negedge clk);
            if (pps_o !== exp_pps(mcnt)) begin
                chk(1'b0, "R2 level", pps_o, exp_pps(mcnt));
            end
            if (pps_o) hi_run++;
            if (pps_o && mcnt == HALF) begin
                if (rise_at >= 0) period = t - rise_at;
                rise_at = t;
            end
        end
        chk(period == MOD, "R1 period", period, MOD);
        chk(hi_run >= 2 * (MOD - HALF) && hi_run <= 2 * (MOD - HALF) + 10, "R2 width", hi_run, 2 * (MOD - HALF));

        // R3/R5/R6/R7: single capture and readout
        pulse_ref(e1, 4);
        chk(cap_valid_o, "R7 set", cap_valid_o, 1);
        chk(!overrun_o, "R8 idle", overrun_o, 0);
        read_word(got);
        chk(got == e1, "R3 R5 R6 value", got, e1);
        chk(!cap_valid_o, "R7 clear", cap_valid_o, 0);

        // R3: capture straddling the wrap
        while (mcnt != MOD - 3) @(negedge clk);
        pulse_ref(e1, 4);
        read_word(got);
        chk(got == e1 && e1 == 0, "R3 wrap", got, 0);

        // R8: two captures without reading
        pulse_ref(e1, 4);
        repeat (30) @(negedge clk);
        pulse_ref(e2, 4);
        chk(overrun_o, "R8 set", overrun_o, 0 + 1);
        chk(cap_valid_o, "R7 still", cap_valid_o, 1);
        read_word(got);
        chk(got == e2, "R8 newest", got, e2);
        chk(!overrun_o, "R8 clear", overrun_o, 0);

        // R4: input held high gives one capture
        pulse_ref(e1, 60);
        read_word(got);
        chk(got == e1, "R4 single", got, e1);

        // R7: capture during a read raises valid again
        pulse_ref(e1, 4);
        strobe(1'b1);
        strobe(1'b0);
        chk(!cap_valid_o, "R7 shift", cap_valid_o, 0);
        pulse_ref(e2, 4);
        chk(cap_valid_o && !overrun_o, "R7 recapture", {cap_valid_o, overrun_o}, 2);
        read_word(got);
        chk(got == e2, "R6 after recapture", got, e2);

        // random phases
        for (int k = 0; k < 20; k++) begin
            repeat ($urandom_range(1500, 1)) @(negedge clk);
            pulse_ref(e1, int'($urandom_range(8, 3)));
            read_word(got);
            chk(got == e1, "R3 R6 random", got, e1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule